// File: doc/BRIEF.md
# SPI ADC Command Engine

This block is a SPI host that drives a multichannel delta-sigma converter. A single valid/ready request port carries three kinds of transaction: a one-byte opcode command, a read of one configuration register, and a write of one configuration register. Each transaction is serialized MSB first in SPI mode 1, with chip-select held low from the first bit to the end. Where the converter needs time to decode a command, the engine holds the bus quiet for a programmable number of host clocks. That gap is derived from a count of converter master-clock periods and rounded up.

A register read sends the opcode `0x20 | addr` and a count byte of `0x00`. The engine then waits out the decode gap and clocks in one data byte. A register write sends `0x40 | addr`, the count byte `0x00` and the value, then holds chip-select low through the decode gap. When each transaction ends, `done` pulses for one cycle. The byte captured by the last read stays on `rd_data` until the next read.

Control is one state machine with these states: IDLE (ready, waiting), SETUP (chip-select drops), LOAD (start one byte), XFER (byte shifting), WAIT (decode gap), FINISH (chip-select rises, done pulse) and HOLD (chip-select kept high). The transitions are:
- IDLE to SETUP when a request is accepted.
- SETUP to LOAD, then LOAD to XFER.
- XFER back to LOAD while bytes remain before the gap.
- XFER to WAIT after the count byte of a read or the value byte of a write.
- WAIT to LOAD for the read data byte, or WAIT to FINISH for a write.
- XFER to FINISH after the only byte of a command or the data byte of a read.
- FINISH to HOLD, then HOLD to IDLE.

Top module: `adc_cmd_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `spi_cs_n` is 1, `spi_sclk` is 0 and `done` is 0.
- R2: A request with `req_kind` 0 or 3 (command) sends exactly one byte equal to `req_opcode` inside one chip-select low window.
- R3: A request with `req_kind` 1 (register read) sends `0x20 | req_addr` and then `0x00`. It then clocks in exactly one byte from `spi_miso`, MSB first, and presents that byte on `rd_data` by the time `done` is seen.
- R4: A request with `req_kind` 2 (register write) sends three bytes inside one chip-select window: `0x40 | req_addr`, `0x00`, then `req_wdata`.
- R5: SPI mode 1 applies. `spi_sclk` idles low. `spi_mosi` changes only at rising edges of `spi_sclk` and stays fixed while it is high. `spi_miso` is sampled at falling edges.
- R6: The decode gap is GAP = ceil(DECODE_CYCLES × HOST_PER_ADC_NUM / HOST_PER_ADC_DEN) host cycles, which is 10 at the defaults. In a read, at least GAP cycles pass between the last falling edge of the count byte and the first rising edge of the data byte, with no SCLK activity. In a write, chip-select stays low for at least GAP cycles after the last falling edge.
- R7: A request is accepted only in IDLE. While a transaction runs, `req_ready` is 0 and a pending request is held until the engine is idle again.
- R8: Between two transactions, `spi_cs_n` stays high for at least 2 host cycles.
- R9: `done` is high for exactly one cycle per transaction, in the cycle where `spi_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_kind | input | 2 | 0/3 command, 1 register read, 2 register write |
| req_opcode | input | 8 | Opcode byte for a command request |
| req_addr | input | 5 | Register address for read or write |
| req_wdata | input | 8 | Value for a register write |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 8 | Byte returned by the last register read |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The hardest situation to reach is a second request that is already waiting while a transaction is still shifting. In that case `req_ready` must stay low, and the held request must start only after the chip-select high spacing. The bench gets there by raising `req_valid` for a command as soon as a read has been accepted and keeping it high. It then checks that the read data is intact and the command bytes are correct. The decode gap is measured on the serial lines by timing the interval between SCLK edges, and the chip-select tail, for every register address in both read and write.

// File: rtl/adc_eng_pkg.sv
package adc_eng_pkg;

    typedef enum logic [1:0] {
        KIND_CMD     = 2'd0,
        KIND_RREG    = 2'd1,
        KIND_WREG    = 2'd2,
        KIND_CMD_ALT = 2'd3
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_XFER,
        ST_WAIT,
        ST_FINISH,
        ST_HOLD
    } eng_state_t;

    localparam logic [7:0] RREG_BASE  = 8'h20;
    localparam logic [7:0] WREG_BASE  = 8'h40;
    localparam logic [7:0] COUNT_BYTE = 8'h00;

    localparam logic [7:0] OPC_SOFT_RESET   = 8'h06;
    localparam logic [7:0] OPC_CONV_START   = 8'h08;
    localparam logic [7:0] OPC_CONV_STOP    = 8'h0A;
    localparam logic [7:0] OPC_OFFSET_CAL   = 8'h1A;
    localparam logic [7:0] OPC_HALT_STREAM  = 8'h11;
    localparam logic [7:0] OPC_FETCH_SAMPLE = 8'h12;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic          active;
    logic [CW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start) begin
                tx_sh   <= tx_byte;
                active  <= 1'b1;
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk    <= 1'b0;
            end else if (active) begin
                if (div_cnt == CW'(HALF_DIV - 1)) begin
                    div_cnt <= '0;
                    if (!sclk) begin
                        // rising edge: present the next bit
                        sclk <= 1'b1;
                        mosi <= tx_sh[7];
                    end else begin
                        // falling edge: capture the returned bit
                        sclk    <= 1'b0;
                        rx_byte <= {rx_byte[6:0], miso};
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        if (bit_cnt == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + CW'(1);
                end
            end
        end
    end

    assert_mosi_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_no_start_mid_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !sclk);

endmodule

// File: rtl/decode_gap_timer.sv
module decode_gap_timer #(
    parameter int GAP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic gap_done
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic          busy;
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            gap_done <= 1'b0;
        end else begin
            gap_done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                remain <= CW'(GAP_CYCLES - 1);
            end else if (busy) begin
                if (remain == '0) begin
                    busy     <= 1'b0;
                    gap_done <= 1'b1;
                end else begin
                    remain <= remain - CW'(1);
                end
            end
        end
    end

    assert_gap_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine
    import adc_eng_pkg::*;
#(
    parameter int HALF_DIV         = 2,
    parameter int DECODE_CYCLES    = 4,
    parameter int HOST_PER_ADC_NUM = 5,
    parameter int HOST_PER_ADC_DEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_kind,
    input  logic [7:0] req_opcode,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int GAP_RAW    = int'(ceil_div(DECODE_CYCLES * HOST_PER_ADC_NUM, HOST_PER_ADC_DEN));
    localparam int GAP_CYCLES = (GAP_RAW > 0) ? GAP_RAW : 1;

    eng_state_t state, next_state;
    logic       is_read, is_write;
    logic [7:0] op_byte, val_byte, tx_byte, rx_byte;
    logic [1:0] byte_idx;
    logic       shift_start, byte_done, gap_start, gap_done;

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (shift_start),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    decode_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gap_start),
        .gap_done (gap_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   if (req_valid) next_state = ST_SETUP;
            ST_SETUP:  next_state = ST_LOAD;
            ST_LOAD:   next_state = ST_XFER;
            ST_XFER: begin
                if (byte_done) begin
                    if (is_read) begin
                        if (byte_idx == 2'd0)      next_state = ST_LOAD;
                        else if (byte_idx == 2'd1) next_state = ST_WAIT;
                        else                       next_state = ST_FINISH;
                    end else if (is_write) begin
                        if (byte_idx == 2'd2) next_state = ST_WAIT;
                        else                  next_state = ST_LOAD;
                    end else begin
                        next_state = ST_FINISH;
                    end
                end
            end
            ST_WAIT:   if (gap_done) next_state = is_read ? ST_LOAD : ST_FINISH;
            ST_FINISH: next_state = ST_HOLD;
            ST_HOLD:   next_state = ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        spi_cs_n    = (state == ST_IDLE) || (state == ST_FINISH) || (state == ST_HOLD);
        done        = (state == ST_FINISH);
        shift_start = (state == ST_LOAD);
        gap_start   = (state == ST_XFER) && (next_state == ST_WAIT);
        if (byte_idx == 2'd0)                  tx_byte = op_byte;
        else if (byte_idx == 2'd2 && is_write) tx_byte = val_byte;
        else                                   tx_byte = COUNT_BYTE;
    end

    // request capture, byte index and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read  <= 1'b0;
            is_write <= 1'b0;
            op_byte  <= '0;
            val_byte <= '0;
            byte_idx <= '0;
            rd_data  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                is_read  <= (req_kind_t'(req_kind) == KIND_RREG);
                is_write <= (req_kind_t'(req_kind) == KIND_WREG);
                val_byte <= req_wdata;
                byte_idx <= '0;
                unique case (req_kind_t'(req_kind))
                    KIND_RREG: op_byte <= RREG_BASE | {3'b000, req_addr};
                    KIND_WREG: op_byte <= WREG_BASE | {3'b000, req_addr};
                    default:   op_byte <= req_opcode;
                endcase
            end else if (state == ST_XFER && byte_done) begin
                byte_idx <= byte_idx + 2'd1;
                if (is_read && byte_idx == 2'd2) rd_data <= rx_byte;
            end
        end
    end

    assert_sclk_within_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !spi_sclk);

    assert_accept_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(req_ready));

    assert_cs_high_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cs_rise_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

endmodule

// File: tb/test_adc_cmd_engine.sv
module test_adc_cmd_engine;
    import adc_eng_pkg::*;

    localparam int HALF_DIV = 2;
    localparam int GAP      = (4 * 5 + 2 - 1) / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = '0;
    logic [7:0] req_opcode = '0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       done;
    logic [7:0] rd_data;
    logic       spi_sclk, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    adc_cmd_engine #(.HALF_DIV(HALF_DIV)) i_adc_cmd_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_opcode(req_opcode), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // serial-side monitor and converter model
    int         cyc = 0;
    int         nbits = 0, nbyte = 0;
    logic [7:0] sh = '0;
    logic [7:0] mon_bytes [0:7];
    logic [7:0] slave_byte = '0;
    int         last_fall = 0, gap_meas = 0, tail_meas = 0;
    int         cs_rise_cyc = 0, min_cs_high = 1000;
    bit         seen_rise = 0;
    int         done_cycles = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && done) done_cycles++;
    end

    always @(negedge spi_cs_n) begin
        nbits = 0;
        nbyte = 0;
        if (seen_rise && (cyc - cs_rise_cyc) < min_cs_high) min_cs_high = cyc - cs_rise_cyc;
    end

    always @(posedge spi_cs_n) begin
        tail_meas   = cyc - last_fall;
        cs_rise_cyc = cyc;
        seen_rise   = rst_n;
    end

    always @(negedge spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        nbits++;
        last_fall = cyc;
        if (nbits % 8 == 0) begin
            mon_bytes[nbyte] = sh;
            nbyte++;
        end
    end

    always @(posedge spi_sclk) begin
        if (nbits == 16) gap_meas = cyc - last_fall;
        spi_miso <= (nbits >= 16 && nbits < 24) ? slave_byte[23 - nbits] : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // caller is at a falling clock edge
    task automatic send(input logic [1:0] k, input logic [7:0] op,
                        input logic [4:0] a, input logic [7:0] wd);
        req_kind   = k;
        req_opcode = op;
        req_addr   = a;
        req_wdata  = wd;
        req_valid  = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] cmds [0:5];
        int         exp_done;
        cmds[0] = OPC_SOFT_RESET;  cmds[1] = OPC_CONV_START; cmds[2] = OPC_CONV_STOP;
        cmds[3] = OPC_OFFSET_CAL;  cmds[4] = OPC_HALT_STREAM; cmds[5] = OPC_FETCH_SAMPLE;
        exp_done = 0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(spi_cs_n == 1'b1,  "R1", "spi_cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0,  "R1", "spi_sclk", spi_sclk, 0);
        chk(done == 1'b0,      "R1", "done", done, 0);

        // R2 commands through both command encodings
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 6; i++) begin
                send(k == 0 ? 2'd0 : 2'd3, cmds[i], 5'd0, 8'h00);
                wait_done();
                exp_done++;
                chk(nbyte == 1, "R2", "byte count", nbyte, 1);
                chk(mon_bytes[0] == cmds[i], "R2", "opcode", mon_bytes[0], cmds[i]);
                chk(spi_sclk == 1'b0, "R5", "sclk idle", spi_sclk, 0);
            end
        end

        // R3 reads over every address, R5 bit order, R6 gap
        for (int a = 0; a < 32; a++) begin
            logic [7:0] sv;
            sv = 8'((a * 37 + 11) ^ 8'hA5);
            slave_byte = sv;
            send(2'd1, 8'hFF, 5'(a), 8'h00);
            wait_done();
            exp_done++;
            chk(nbyte == 3, "R3", "byte count", nbyte, 3);
            chk(mon_bytes[0] == (8'h20 | 8'(a)), "R3", "read opcode", mon_bytes[0], 8'h20 | a);
            chk(mon_bytes[1] == 8'h00, "R3", "count byte", mon_bytes[1], 0);
            chk(rd_data == sv, "R5", "read data sampled on falling edge", rd_data, sv);
            chk(gap_meas >= GAP, "R6", "read decode gap", gap_meas, GAP);
        end

        // R4 writes over every address, R6 tail
        for (int a = 0; a < 32; a++) begin
            logic [7:0] wv;
            wv = 8'(a * 53 + 7);
            send(2'd2, 8'hFF, 5'(a), wv);
            wait_done();
            exp_done++;
            chk(nbyte == 3, "R4", "byte count", nbyte, 3);
            chk(mon_bytes[0] == (8'h40 | 8'(a)), "R4", "write opcode", mon_bytes[0], 8'h40 | a);
            chk(mon_bytes[1] == 8'h00, "R4", "count byte", mon_bytes[1], 0);
            chk(mon_bytes[2] == wv, "R4", "value byte", mon_bytes[2], wv);
            chk(tail_meas >= GAP, "R6", "write decode tail", tail_meas, GAP);
        end

        // R7 request held off while busy
        slave_byte = 8'h3C;
        send(2'd1, 8'h00, 5'd5, 8'h00);
        exp_done++;
        req_kind   = 2'd0;
        req_opcode = OPC_CONV_START;
        req_valid  = 1'b1;
        chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        repeat (20) @(negedge clk);
        chk(req_ready == 1'b0, "R7", "ready mid transfer", req_ready, 0);
        send(2'd0, OPC_CONV_START, 5'd0, 8'h00);
        wait_done();
        exp_done++;
        chk(rd_data == 8'h3C, "R7", "earlier read intact", rd_data, 8'h3C);
        chk(nbyte == 1 && mon_bytes[0] == OPC_CONV_START, "R7", "held command",
            mon_bytes[0], OPC_CONV_START);

        // R8 / R9 over the whole run
        chk(min_cs_high >= 2, "R8", "cs high spacing", min_cs_high, 2);
        chk(done_cycles == exp_done, "R9", "done cycles", done_cycles, exp_done);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule